// File: doc/BRIEF.md
# DRAM Mode-Register Initialization Sequencer

This block walks a memory controller through the power-up mode-register programming of DDR2 or DDR3 devices. A single `start` pulse latches the memory type, the timing values (write recovery, CAS latency, CAS write latency) and a mask of populated ranks. The sequencer first runs a short preamble: a NOP, a one-cycle drop of the controller's init enable, and a 2 µs settle. It then visits each populated rank in ascending order and issues that rank's complete command list before it moves to the next rank. Each command carries a 3-bit code, an extended-register select, a rank number and a mode-register value. The value is given as a byte address, so every field sits 3 bits above its DRAM address pin, because the data bus is 8 bytes wide.

Commands leave through a valid/ready port. While `cmd_valid` is high and `cmd_ready` is low, the sequencer holds every command field steady. A command counts as delivered on the clock edge where both signals are high. The downstream side may apply back-pressure for any number of cycles. No command is dropped or repeated. The microsecond waits are counted in clock cycles, scaled by the `CLK_MHZ` parameter. A DDR3 write-recovery value with no encoding raises `error` and nothing is issued.

Top module: `dram_mrs_seq`

## Requirements
- R1: After reset, `cmd_valid`, `done` and `error` are low and `init_en` is high.
- R2: A start with a non-empty mask first issues one NOP (code 1, rank 0, value 0). In the cycle after the NOP handshake, `init_en` is low for exactly one cycle. The first rank command then becomes valid 2*CLK_MHZ+2 clock edges after the NOP handshake edge.
- R3: Command codes are: read access 0, NOP 1, precharge-all 2, base mode register 3, extended mode register 4, refresh 6. For code 4, the select equals the extended register index minus one; for all other codes it is 0. Each DDR2 rank receives these commands in order: precharge-all; EMR2=0; EMR3=0; EMR1 (ODT); MR with DLL reset; precharge-all; refresh; read with value 0; MR without DLL reset; EMR1 (OCD default + ODT); EMR1 (ODT).
- R4: The DDR2 MR value is built as follows. Bits 14:12 hold tWR−1 (3 bits). Bit 11 holds DLL reset. Bits 9:7 hold the CAS latency (3 bits). Bit 6 is set (interleaved). Bits 5:3 hold 3 (burst of 8).
- R5: The DDR2 EMR1 value sets bit 9 (ODT 150 Ω) with bit 5 clear. The OCD-default variant also sets bits 12:10 to 7.
- R6: Each DDR3 rank receives these commands in order: MR2 = (CWL−5)<<6; MR3 = 0; MR1 = bit 9 (ODT 120 Ω) | bit 4 (34 Ω drive); MR0 with DLL reset; MR0 without it. MR0 is built as follows. Bits 14:12 hold the write-recovery code. Bit 11 holds DLL reset. Bits 9:7 hold CL−4. Bit 6 is set (interleaved).
- R7: The DDR3 write-recovery code for tWR 5,6,7,8,9,10,11,12 is 1,2,3,4,5,5,6,6 respectively.
- R8: A DDR3 start with tWR below 5 or above 12 raises `error` in the cycle after the start edge. `error` stays high until the next start. No command and no `done` follow it.
- R9: Only ranks whose mask bit is set are programmed, in ascending rank order. All commands for one rank finish before any command for the next rank.
- R10: After the refresh handshake the sequencer waits 1 µs. The next command becomes valid exactly CLK_MHZ edges after the refresh handshake edge.
- R11: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid` stays high and the code, select, rank and value do not change.
- R12: `done` is high for one cycle. It follows the last handshake by one edge. With an all-zero mask, it follows the start edge directly and no command is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sequence (sampled while idle) |
| mem_ddr3 | input | 1 | 1 = DDR3 order, 0 = DDR2 order |
| twr_cyc | input | 4 | Write-recovery time in clocks |
| cas_lat | input | 4 | CAS latency |
| cas_wr_lat | input | 4 | CAS write latency (DDR3) |
| rank_mask | input | NUM_RANKS | Populated-rank mask |
| cmd_ready | input | 1 | Downstream accepts the command |
| cmd_valid | output | 1 | Command present |
| cmd_code | output | 3 | Command code |
| cmd_ereg | output | 2 | Extended-register select (index−1) |
| cmd_rank | output | RANK_W | Target rank |
| cmd_addr | output | ADDR_W | Mode-register value (byte-address form) |
| init_en | output | 1 | Controller init enable |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Unsupported timing value |

## Verification
Every timed result is checked against its fixed edge count:
- A 2*CLK_MHZ+2 edge gap from the NOP handshake to the first rank command.
- A CLK_MHZ edge gap from the refresh handshake to the dummy read.
- One edge from the last handshake to `done`.
- Zero edges from the start edge to `done` with an empty mask.
- Zero edges from the start edge to `error` with a bad DDR3 tWR.

The bench counts clock edges and samples on falling edges. A handshake seen there is attributed to the following rising edge. A level first seen there is attributed to the preceding rising edge. Back-pressure comes from a pseudo-random ready pattern. The recorded stream is compared entry by entry, so a stalled command must still appear exactly once.

// File: rtl/dram_mrs_pkg.sv
package dram_mrs_pkg;

  typedef enum logic [2:0] {
    CMD_READ = 3'd0,
    CMD_NOP  = 3'd1,
    CMD_PREA = 3'd2,
    CMD_MRS  = 3'd3,
    CMD_EMRS = 3'd4,
    CMD_REF  = 3'd6
  } cmd_code_e;

  typedef enum logic [2:0] {
    VAL_ZERO,
    VAL_MR_DLL,
    VAL_MR_RUN,
    VAL_EMR1,
    VAL_EMR1_OCD,
    VAL_MR2
  } val_sel_e;

  typedef struct packed {
    cmd_code_e code;
    logic [1:0] ereg;
    val_sel_e   vsel;
    logic       wait_after;
    logic       last;
  } step_t;

  localparam int STEP_W = 4;

  function automatic logic twr_supported(input logic [3:0] t);
    return (t >= 4'd5) && (t <= 4'd12);
  endfunction

  function automatic logic [2:0] ddr3_wr_code(input logic [3:0] t);
    logic [2:0] c;
    case (t)
      4'd5:          c = 3'd1;
      4'd6:          c = 3'd2;
      4'd7:          c = 3'd3;
      4'd8:          c = 3'd4;
      4'd9, 4'd10:   c = 3'd5;
      4'd11, 4'd12:  c = 3'd6;
      default:       c = 3'd0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/dram_mrs_steps.sv
module dram_mrs_steps
  import dram_mrs_pkg::*;
(
  input  logic              is_ddr3,
  input  logic [STEP_W-1:0] idx,
  output step_t             st
);

  function automatic step_t mk(input cmd_code_e c, input logic [1:0] e,
                               input val_sel_e v, input logic w, input logic l);
    step_t s;
    s.code = c;
    s.ereg = e;
    s.vsel = v;
    s.wait_after = w;
    s.last = l;
    return s;
  endfunction

  step_t ddr2_st, ddr3_st;

  always_comb begin
    case (idx)
      4'd0:    ddr2_st = mk(CMD_PREA, 2'd0, VAL_ZERO,     1'b0, 1'b0);
      4'd1:    ddr2_st = mk(CMD_EMRS, 2'd1, VAL_ZERO,     1'b0, 1'b0);
      4'd2:    ddr2_st = mk(CMD_EMRS, 2'd2, VAL_ZERO,     1'b0, 1'b0);
      4'd3:    ddr2_st = mk(CMD_EMRS, 2'd0, VAL_EMR1,     1'b0, 1'b0);
      4'd4:    ddr2_st = mk(CMD_MRS,  2'd0, VAL_MR_DLL,   1'b0, 1'b0);
      4'd5:    ddr2_st = mk(CMD_PREA, 2'd0, VAL_ZERO,     1'b0, 1'b0);
      4'd6:    ddr2_st = mk(CMD_REF,  2'd0, VAL_ZERO,     1'b1, 1'b0);
      4'd7:    ddr2_st = mk(CMD_READ, 2'd0, VAL_ZERO,     1'b0, 1'b0);
      4'd8:    ddr2_st = mk(CMD_MRS,  2'd0, VAL_MR_RUN,   1'b0, 1'b0);
      4'd9:    ddr2_st = mk(CMD_EMRS, 2'd0, VAL_EMR1_OCD, 1'b0, 1'b0);
      default: ddr2_st = mk(CMD_EMRS, 2'd0, VAL_EMR1,     1'b0, 1'b1);
    endcase
  end

  always_comb begin
    case (idx)
      4'd0:    ddr3_st = mk(CMD_EMRS, 2'd1, VAL_MR2,    1'b0, 1'b0);
      4'd1:    ddr3_st = mk(CMD_EMRS, 2'd2, VAL_ZERO,   1'b0, 1'b0);
      4'd2:    ddr3_st = mk(CMD_EMRS, 2'd0, VAL_EMR1,   1'b0, 1'b0);
      4'd3:    ddr3_st = mk(CMD_MRS,  2'd0, VAL_MR_DLL, 1'b0, 1'b0);
      default: ddr3_st = mk(CMD_MRS,  2'd0, VAL_MR_RUN, 1'b0, 1'b1);
    endcase
  end

  assign st = is_ddr3 ? ddr3_st : ddr2_st;

endmodule

// File: rtl/dram_mrs_encode.sv
module dram_mrs_encode
  import dram_mrs_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              is_ddr3,
  input  logic [3:0]        twr,
  input  logic [3:0]        cas,
  input  logic [3:0]        cwl,
  input  val_sel_e          vsel,
  output logic [ADDR_W-1:0] value
);

  localparam logic [31:0] BIT_DLL   = 32'h0000_0800;
  localparam logic [31:0] BIT_INTLV = 32'h0000_0040;
  localparam logic [31:0] BL8_FLD   = 32'h0000_0018;
  localparam logic [31:0] ODT_150   = 32'h0000_0200;
  localparam logic [31:0] OCD_DFLT  = 32'h0000_1C00;
  localparam logic [31:0] ODT_120   = 32'h0000_0200;
  localparam logic [31:0] DRV_34    = 32'h0000_0010;

  logic [3:0]  twr_m1, cl_m4, cwl_m5;
  logic [31:0] d2_mr, d3_mr, mr_run, emr1, v32;

  assign twr_m1 = twr - 4'd1;
  assign cl_m4  = cas - 4'd4;
  assign cwl_m5 = cwl - 4'd5;

  assign d2_mr = (32'(twr_m1[2:0]) << 12) | (32'(cas[2:0]) << 7) | BIT_INTLV | BL8_FLD;
  assign d3_mr = (32'(ddr3_wr_code(twr)) << 12) | (32'(cl_m4[2:0]) << 7) | BIT_INTLV;

  assign mr_run = is_ddr3 ? d3_mr : d2_mr;
  assign emr1   = is_ddr3 ? (ODT_120 | DRV_34) : ODT_150;

  always_comb begin
    case (vsel)
      VAL_MR_DLL:   v32 = mr_run | BIT_DLL;
      VAL_MR_RUN:   v32 = mr_run;
      VAL_EMR1:     v32 = emr1;
      VAL_EMR1_OCD: v32 = emr1 | OCD_DFLT;
      VAL_MR2:      v32 = 32'(cwl_m5[2:0]) << 6;
      default:      v32 = 32'd0;
    endcase
  end

  assign value = v32[ADDR_W-1:0];

endmodule

// File: rtl/dram_mrs_delay.sv
module dram_mrs_delay #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expire = (cnt == CNT_W'(1));

endmodule

// File: rtl/dram_mrs_rank_pick.sv
module dram_mrs_rank_pick #(
  parameter int NUM_RANKS = 4,
  parameter int RANK_W    = 2
) (
  input  logic [NUM_RANKS-1:0] mask,
  input  logic [RANK_W:0]      from_idx,
  output logic                 found,
  output logic [RANK_W-1:0]    idx
);

  logic [NUM_RANKS-1:0] cand;

  for (genvar i = 0; i < NUM_RANKS; i++) begin : g_cand
    assign cand[i] = mask[i] && ((RANK_W+1)'(i) >= from_idx);
  end

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NUM_RANKS - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found = 1'b1;
        idx   = RANK_W'(i);
      end
    end
  end

endmodule

// File: rtl/dram_mrs_seq.sv
module dram_mrs_seq
  import dram_mrs_pkg::*;
#(
  parameter int NUM_RANKS = 4,
  parameter int CLK_MHZ   = 50,
  parameter int ADDR_W    = 16,
  localparam int RANK_W   = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 mem_ddr3,
  input  logic [3:0]           twr_cyc,
  input  logic [3:0]           cas_lat,
  input  logic [3:0]           cas_wr_lat,
  input  logic [NUM_RANKS-1:0] rank_mask,
  input  logic                 cmd_ready,
  output logic                 cmd_valid,
  output logic [2:0]           cmd_code,
  output logic [1:0]           cmd_ereg,
  output logic [RANK_W-1:0]    cmd_rank,
  output logic [ADDR_W-1:0]    cmd_addr,
  output logic                 init_en,
  output logic                 done,
  output logic                 error
);

  localparam int DLY_SETTLE = 2 * CLK_MHZ;
  localparam int DLY_REF    = CLK_MHZ;
  localparam int CNT_W      = $clog2(DLY_SETTLE + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_NOP, S_EN_OFF, S_EN_WAIT, S_PICK, S_ISSUE, S_WAIT, S_DONE
  } state_e;

  state_e               state;
  logic [STEP_W-1:0]    step;
  logic [RANK_W-1:0]    cur_rank;
  logic [RANK_W:0]      next_from;
  logic                 cfg_ddr3;
  logic [3:0]           cfg_twr, cfg_cas, cfg_cwl;
  logic [NUM_RANKS-1:0] cfg_mask;
  logic                 err_q;

  step_t                st;
  logic [ADDR_W-1:0]    enc_val;
  logic                 pick_found;
  logic [RANK_W-1:0]    pick_idx;
  logic                 dly_load, dly_expire;
  logic [CNT_W-1:0]     dly_val;
  logic                 hs;

  dram_mrs_steps u_steps (
    .is_ddr3 (cfg_ddr3),
    .idx     (step),
    .st      (st)
  );

  dram_mrs_encode #(.ADDR_W(ADDR_W)) u_enc (
    .is_ddr3 (cfg_ddr3),
    .twr     (cfg_twr),
    .cas     (cfg_cas),
    .cwl     (cfg_cwl),
    .vsel    (st.vsel),
    .value   (enc_val)
  );

  dram_mrs_rank_pick #(.NUM_RANKS(NUM_RANKS), .RANK_W(RANK_W)) u_pick (
    .mask     (cfg_mask),
    .from_idx (next_from),
    .found    (pick_found),
    .idx      (pick_idx)
  );

  dram_mrs_delay #(.CNT_W(CNT_W)) u_dly (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (dly_load),
    .load_val (dly_val),
    .expire   (dly_expire)
  );

  assign hs       = cmd_valid && cmd_ready;
  assign dly_load = (state == S_EN_OFF) || (state == S_ISSUE && hs && st.wait_after);
  assign dly_val  = (state == S_EN_OFF) ? CNT_W'(DLY_SETTLE) : CNT_W'(DLY_REF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      step      <= '0;
      cur_rank  <= '0;
      next_from <= '0;
      cfg_ddr3  <= 1'b0;
      cfg_twr   <= '0;
      cfg_cas   <= '0;
      cfg_cwl   <= '0;
      cfg_mask  <= '0;
      err_q     <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (start) begin
            cfg_ddr3  <= mem_ddr3;
            cfg_twr   <= twr_cyc;
            cfg_cas   <= cas_lat;
            cfg_cwl   <= cas_wr_lat;
            cfg_mask  <= rank_mask;
            next_from <= '0;
            err_q     <= 1'b0;
            if (mem_ddr3 && !twr_supported(twr_cyc)) begin
              err_q <= 1'b1;
            end else if (rank_mask == '0) begin
              state <= S_DONE;
            end else begin
              state <= S_NOP;
            end
          end
        end
        S_NOP: begin
          if (cmd_ready) state <= S_EN_OFF;
        end
        S_EN_OFF: begin
          state <= S_EN_WAIT;
        end
        S_EN_WAIT: begin
          if (dly_expire) state <= S_PICK;
        end
        S_PICK: begin
          if (pick_found) begin
            cur_rank <= pick_idx;
            step     <= '0;
            state    <= S_ISSUE;
          end else begin
            state <= S_DONE;
          end
        end
        S_ISSUE: begin
          if (cmd_ready) begin
            if (st.last) begin
              next_from <= (RANK_W+1)'(cur_rank) + (RANK_W+1)'(1);
              state     <= S_PICK;
            end else begin
              step <= step + 1'b1;
              if (st.wait_after) state <= S_WAIT;
            end
          end
        end
        S_WAIT: begin
          if (dly_expire) state <= S_ISSUE;
        end
        default: begin
          state <= S_IDLE;
        end
      endcase
    end
  end

  always_comb begin
    cmd_valid = (state == S_NOP) || (state == S_ISSUE);
    if (state == S_NOP) begin
      cmd_code = CMD_NOP;
      cmd_ereg = 2'd0;
      cmd_rank = '0;
      cmd_addr = '0;
    end else begin
      cmd_code = st.code;
      cmd_ereg = st.ereg;
      cmd_rank = cur_rank;
      cmd_addr = enc_val;
    end
  end

  assign init_en = (state != S_EN_OFF);
  assign done    = (state == S_DONE);
  assign error   = err_q;

endmodule

// File: rtl/dram_mrs_seq_chk.sv
module dram_mrs_seq_chk #(
  parameter int NUM_RANKS = 4,
  parameter int RANK_W    = 2,
  parameter int ADDR_W    = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_RANKS-1:0] rank_mask,
  input logic                 cmd_ready,
  input logic                 cmd_valid,
  input logic [2:0]           cmd_code,
  input logic [1:0]           cmd_ereg,
  input logic [RANK_W-1:0]    cmd_rank,
  input logic [ADDR_W-1:0]    cmd_addr,
  input logic                 init_en,
  input logic                 done,
  input logic                 error
);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_code) && $stable(cmd_ereg)
                                   && $stable(cmd_rank) && $stable(cmd_addr)));

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> (!cmd_valid && !done));

  p_en_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !init_en |=> init_en);

  p_en_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !init_en |-> !cmd_valid);

  p_rank_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code != 3'd1) |-> rank_mask[cmd_rank]);

endmodule

bind dram_mrs_seq dram_mrs_seq_chk #(
  .NUM_RANKS (NUM_RANKS),
  .RANK_W    (RANK_W),
  .ADDR_W    (ADDR_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .rank_mask (rank_mask),
  .cmd_ready (cmd_ready),
  .cmd_valid (cmd_valid),
  .cmd_code  (cmd_code),
  .cmd_ereg  (cmd_ereg),
  .cmd_rank  (cmd_rank),
  .cmd_addr  (cmd_addr),
  .init_en   (init_en),
  .done      (done),
  .error     (error)
);

// File: tb/dram_mrs_seq_tb.sv
module dram_mrs_seq_tb_top;

  localparam int NR  = 4;
  localparam int MHZ = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic mem_ddr3 = 1'b0;
  logic [3:0] twr_cyc = 4'd0, cas_lat = 4'd0, cas_wr_lat = 4'd0;
  logic [NR-1:0] rank_mask = '0;
  logic cmd_ready = 1'b1;
  logic cmd_valid;
  logic [2:0] cmd_code;
  logic [1:0] cmd_ereg;
  logic [1:0] cmd_rank;
  logic [15:0] cmd_addr;
  logic init_en, done, error;

  always #10 clk = ~clk;

  dram_mrs_seq #(.NUM_RANKS(NR), .CLK_MHZ(MHZ), .ADDR_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_ddr3(mem_ddr3),
    .twr_cyc(twr_cyc), .cas_lat(cas_lat), .cas_wr_lat(cas_wr_lat),
    .rank_mask(rank_mask), .cmd_ready(cmd_ready), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .cmd_ereg(cmd_ereg), .cmd_rank(cmd_rank),
    .cmd_addr(cmd_addr), .init_en(init_en), .done(done), .error(error)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  // expected command stream
  logic [22:0] exp_ent [64];
  string       exp_tag [64];
  int          exp_n;

  task automatic push(input int code, input int sel, input int rank, input int val,
                      input string tag);
    exp_ent[exp_n] = {3'(code), 2'(sel), 2'(rank), 16'(val)};
    exp_tag[exp_n] = tag;
    exp_n++;
  endtask

  function automatic int d3_wr(input int t);
    return (t <= 8) ? (t - 4) : ((t + 1) / 2);
  endfunction

  task automatic build(input bit d3, input int twr, input int cl, input int cw,
                       input logic [NR-1:0] m);
    int mr2, mr0, e1;
    exp_n = 0;
    if (m != '0) push(1, 0, 0, 0, "R2");
    for (int r = 0; r < NR; r++) begin
      if (m[r]) begin
        if (!d3) begin
          mr0 = (((twr - 1) & 7) << 12) | ((cl & 7) << 7) | (1 << 6) | (3 << 3);
          e1  = 1 << 9;
          push(2, 0, r, 0, "R3");
          push(4, 1, r, 0, "R3");
          push(4, 2, r, 0, "R3");
          push(4, 0, r, e1, "R5");
          push(3, 0, r, mr0 | (1 << 11), "R4");
          push(2, 0, r, 0, "R3");
          push(6, 0, r, 0, "R3");
          push(0, 0, r, 0, "R3");
          push(3, 0, r, mr0, "R4");
          push(4, 0, r, e1 | (7 << 10), "R5");
          push(4, 0, r, e1, "R5");
        end else begin
          mr2 = ((cw - 5) & 7) << 6;
          mr0 = (d3_wr(twr) << 12) | (((cl - 4) & 7) << 7) | (1 << 6);
          e1  = (1 << 9) | (1 << 4);
          push(4, 1, r, mr2, "R6");
          push(4, 2, r, 0, "R6");
          push(4, 0, r, e1, "R6");
          push(3, 0, r, mr0 | (1 << 11), "R7");
          push(3, 0, r, mr0, "R7");
        end
      end
    end
  endtask

  // monitor state
  int obs_n, last_hs, nop_hs, ref_hs, done_cnt, done_cyc, en_low, hold_bad;
  bit want_nop, want_ref, held;
  logic [22:0] held_v;

  task automatic mon_clear();
    obs_n = 0; last_hs = 0; nop_hs = 0; ref_hs = 0; done_cnt = 0; done_cyc = 0;
    en_low = 0; hold_bad = 0; want_nop = 0; want_ref = 0; held = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      logic [22:0] cur;
      cur = {cmd_code, cmd_ereg, cmd_rank, cmd_addr};
      if (held && (!cmd_valid || cur != held_v)) hold_bad++;
      held   = cmd_valid && !cmd_ready;
      held_v = cur;
      if (cmd_valid && want_nop) begin
        check(cyc - nop_hs == 2 * MHZ + 2, "R2", "settle gap", cyc - nop_hs, 2 * MHZ + 2);
        want_nop = 0;
      end
      if (cmd_valid && want_ref) begin
        check(cyc - ref_hs == MHZ, "R10", "refresh wait", cyc - ref_hs, MHZ);
        want_ref = 0;
      end
      if (cmd_valid && cmd_ready) begin
        if (obs_n < exp_n) begin
          check(cur == exp_ent[obs_n], exp_tag[obs_n], "command entry", cur, exp_ent[obs_n]);
          check(cmd_rank == exp_ent[obs_n][17:16], "R9", "rank order", cmd_rank,
                exp_ent[obs_n][17:16]);
        end
        if (obs_n == 0) begin nop_hs = cyc + 1; want_nop = 1; end
        if (cmd_code == 3'd6) begin ref_hs = cyc + 1; want_ref = 1; end
        last_hs = cyc + 1;
        obs_n++;
      end
      if (!init_en) en_low++;
      if (done) begin done_cnt++; done_cyc = cyc; end
    end
  end

  // ready pattern
  bit rdy_rand = 1'b0;
  logic [7:0] lfsr = 8'hA5;
  initial begin
    forever begin
      @(posedge clk);
      #2;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      cmd_ready = rdy_rand ? (lfsr[1] | lfsr[4]) : 1'b1;
    end
  end

  int start_cyc;

  task automatic kick(input bit d3, input int twr, input int cl, input int cw,
                      input logic [NR-1:0] m);
    @(posedge clk);
    #2;
    mon_clear();
    mem_ddr3 = d3; twr_cyc = 4'(twr); cas_lat = 4'(cl); cas_wr_lat = 4'(cw);
    rank_mask = m;
    start = 1'b1;
    @(posedge clk);
    #1 start_cyc = cyc;
    #1 start = 1'b0;
  endtask

  task automatic run_case(input bit d3, input int twr, input int cl, input int cw,
                          input logic [NR-1:0] m);
    build(d3, twr, cl, cw, m);
    kick(d3, twr, cl, cw, m);
    for (int k = 0; k < 5000 && done_cnt == 0; k++) @(posedge clk);
    repeat (4) @(posedge clk);
    #12;
    check(obs_n == exp_n, "R9", "command count", obs_n, exp_n);
    check(done_cnt == 1, "R12", "done cycles", done_cnt, 1);
    if (m == '0)
      check(done_cyc - start_cyc == 0, "R12", "empty-mask done gap", done_cyc - start_cyc, 0);
    else
      check(done_cyc - last_hs == 1, "R12", "done gap", done_cyc - last_hs, 1);
    check(en_low == ((m != '0) ? 1 : 0), "R2", "init enable low cycles", en_low,
          (m != '0) ? 1 : 0);
    check(hold_bad == 0, "R11", "hold under back-pressure", hold_bad, 0);
    check(error == 1'b0, "R8", "error clear", error, 0);
  endtask

  task automatic run_err(input int twr);
    build(1'b1, twr, 6, 5, 4'b0101);
    exp_n = 0;
    kick(1'b1, twr, 6, 5, 4'b0101);
    #8;
    check(error == 1'b1, "R8", "error after start edge", error, 1);
    repeat (300) @(posedge clk);
    #12;
    check(obs_n == 0, "R8", "commands after error", obs_n, 0);
    check(done_cnt == 0, "R8", "done after error", done_cnt, 0);
    check(error == 1'b1, "R8", "error held", error, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: act=%0d exp=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    exp_n = 0;
    mon_clear();
    repeat (5) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    check(cmd_valid == 1'b0, "R1", "valid after reset", cmd_valid, 0);
    check(done == 1'b0, "R1", "done after reset", done, 0);
    check(error == 1'b0, "R1", "error after reset", error, 0);
    check(init_en == 1'b1, "R1", "init enable after reset", init_en, 1);

    // sweep all rank masks for both memory types
    for (int mi = 0; mi < 16; mi++) begin
      rdy_rand = mi[0];
      if (mi[1]) run_case(1'b0, 6, 5, 0, 4'(mi));
      else       run_case(1'b0, 3, 4, 0, 4'(mi));
      if (mi[1]) run_case(1'b1, 10, 9, 7, 4'(mi));
      else       run_case(1'b1, 5, 6, 5, 4'(mi));
    end

    // DDR2 write-recovery and CAS field sweep
    rdy_rand = 1'b1;
    for (int t = 2; t <= 9; t++) run_case(1'b0, t, 3 + (t % 4), 0, 4'b0001);

    // DDR3 write-recovery table
    rdy_rand = 1'b0;
    for (int t = 5; t <= 12; t++) run_case(1'b1, t, 5 + (t % 6), 5 + (t % 4), 4'b0010);

    // unsupported DDR3 write recovery
    run_err(4);
    run_err(13);
    run_err(0);
    run_case(1'b1, 8, 7, 6, 4'b1000);
    run_err(15);
    run_case(1'b0, 15, 6, 0, 4'b0100);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule